// File: doc/BRIEF.md
# Segment Register with Hidden Descriptor Cache

This block holds one segment register. The register has two parts. The selector is the part a program can see. The hidden descriptor copy is the part hardware fills. Writing a selector starts a descriptor fetch from one of two descriptor tables through a simple read port. The table is chosen by the lowest selector bit, and the entry by the remaining bits. When the descriptor comes back, its present bit is checked once. If the segment is absent, the load reports a fault and the segment is left unusable. Otherwise the base, limit and code/data type are stored in the hidden copy.

After a load, every access through the segment is judged against the hidden copy alone, and the table is never read again. Each access gives either a linear address (base plus offset) or a fault code, one cycle after the request. While a fetch is in flight, the block drops `ready`. Any access issued then is answered with a busy code, and any further selector write is ignored.

Top module: `seg_reg_unit`

## Requirements
- R1: A selector write while `ready` is high is captured in `sel_visible` and causes exactly one table read, one cycle later. The read address puts selector bit 0 (table choice) in its top bit and selector bits [IDX_W:1] (entry index) below it.
- R2: `ready` is low from the cycle after an accepted selector write until the response is taken. `load_done` pulses for one cycle in the cycle `ready` returns high.
- R3: Descriptor word layout: bit 0 is present, bit 1 marks a code segment, bits [LIM_W+1:2] hold the limit, and the upper BASE_W bits hold the base. A descriptor with bit 0 clear gives `load_fault` = 1 and leaves the segment unusable. A present descriptor gives `load_fault` = 0 and fills the hidden copy.
- R4: An access requested while `ready` is low returns fault code 5 (busy), and starts no table read.
- R5: An access to a segment that was never loaded, or whose last load was absent, returns fault code 6 (invalid).
- R6: An offset greater than the cached limit returns fault code 2. This check takes priority over the type checks, and an offset equal to the limit is allowed.
- R7: A write (`acc_kind` = 1) to a code segment returns fault code 3.
- R8: A fetch (`acc_kind` = 2) from a data segment returns fault code 4. Reads (`acc_kind` = 0 or 3) are allowed on both types, writes to data segments are allowed, and fetches from code segments are allowed.
- R9: A permitted access returns fault code 0 and `res_linear` = (base + offset) mod 2^BASE_W. Results appear exactly one cycle after the request. `res_linear` is 0 whenever the fault code is non-zero.
- R10: A selector write while `ready` is low is ignored: `sel_visible` is unchanged and no extra table read occurs.
- R11: Accesses never read the table; the number of table reads equals the number of accepted selector writes.
- R12: After reset, `ready` is high, no result or load completion is signalled, no table read is issued, and the segment is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_load | input | 1 | Write a new selector |
| sel_value | input | IDX_W+1 | Selector: bit 0 table choice, upper bits entry index |
| sel_visible | output | IDX_W+1 | Currently held selector |
| ready | output | 1 | No descriptor fetch in flight |
| load_done | output | 1 | One-cycle pulse when a fetch finishes |
| load_fault | output | 3 | Result code of the last load (0 or 1) |
| tbl_rd_en | output | 1 | Descriptor read request |
| tbl_rd_addr | output | IDX_W+1 | {table choice, entry index} |
| tbl_rd_data | input | BASE_W+LIM_W+2 | Returned descriptor |
| tbl_rd_valid | input | 1 | Descriptor data valid |
| acc_valid | input | 1 | Access request |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| acc_offset | input | LIM_W | Offset within the segment |
| res_valid | output | 1 | Access result valid |
| res_linear | output | BASE_W | Linear address |
| res_fault | output | 3 | Access fault code |

## Verification
Every entry of both tables in a small configuration is loaded, each with its own response latency. The mix of present and absent entries separates a load-time fault from later access-time faults. For each loaded segment, the three access kinds are tried at offset zero, at half the limit, at the limit, one past the limit and at the largest offset. This separates the limit boundary, the limit-over-type priority and the code/data type rules. A base near the top of the address range exercises wrap-around of the linear address. Each fetch window is also used to issue an access and a second selector write, which separates the busy response from an ignored load.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [2:0] {
    F_NONE    = 3'd0,
    F_ABSENT  = 3'd1,
    F_LIMIT   = 3'd2,
    F_WR_CODE = 3'd3,
    F_EX_DATA = 3'd4,
    F_BUSY    = 3'd5,
    F_INVALID = 3'd6
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ     = 2'd0,
    ACC_WRITE    = 2'd1,
    ACC_FETCH    = 2'd2,
    ACC_ALT_READ = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } fetch_st_e;
endpackage

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import seg_pkg::*;
#(
  parameter int IDX_W  = 13,
  parameter int BASE_W = 24,
  parameter int LIM_W  = 16,
  localparam int SEL_W  = IDX_W + 1,
  localparam int DESC_W = BASE_W + LIM_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_load,
  input  logic [SEL_W-1:0]  sel_value,
  output logic [SEL_W-1:0]  sel_visible,
  output logic              ready,
  output logic              load_done,
  output logic [2:0]        load_code,
  output logic              tbl_rd_en,
  output logic [SEL_W-1:0]  tbl_rd_addr,
  input  logic [DESC_W-1:0] tbl_rd_data,
  input  logic              tbl_rd_valid,
  output logic              seg_ok,
  output logic              seg_code,
  output logic [BASE_W-1:0] seg_base,
  output logic [LIM_W-1:0]  seg_limit
);
  // selector {index, table} -> table address {table, index}
  function automatic logic [SEL_W-1:0] table_addr(input logic [SEL_W-1:0] s);
    return {s[0], s[SEL_W-1:1]};
  endfunction

  function automatic logic d_present(input logic [DESC_W-1:0] d);
    return d[0];
  endfunction

  function automatic logic d_is_code(input logic [DESC_W-1:0] d);
    return d[1];
  endfunction

  function automatic logic [LIM_W-1:0] d_limit(input logic [DESC_W-1:0] d);
    return d[LIM_W+1:2];
  endfunction

  function automatic logic [BASE_W-1:0] d_base(input logic [DESC_W-1:0] d);
    return d[DESC_W-1:LIM_W+2];
  endfunction

  fetch_st_e  state;
  logic [SEL_W-1:0] sel_q;

  // named internal events
  logic load_accept;
  logic rsp_take;

  assign ready       = (state == ST_IDLE);
  assign load_accept = ready && sel_load;
  assign rsp_take    = (state == ST_WAIT) && tbl_rd_valid;
  assign tbl_rd_en   = (state == ST_ISSUE);
  assign tbl_rd_addr = table_addr(sel_q);
  assign sel_visible = sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sel_q     <= '0;
      seg_ok    <= 1'b0;
      seg_code  <= 1'b0;
      seg_base  <= '0;
      seg_limit <= '0;
      load_done <= 1'b0;
      load_code <= F_NONE;
    end else begin
      load_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (load_accept) begin
            sel_q  <= sel_value;
            seg_ok <= 1'b0;
            state  <= ST_ISSUE;
          end
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: begin
          if (rsp_take) begin
            state     <= ST_IDLE;
            load_done <= 1'b1;
            if (d_present(tbl_rd_data)) begin
              seg_ok    <= 1'b1;
              seg_code  <= d_is_code(tbl_rd_data);
              seg_base  <= d_base(tbl_rd_data);
              seg_limit <= d_limit(tbl_rd_data);
              load_code <= F_NONE;
            end else begin
              load_code <= F_ABSENT;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r1_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd_en |=> !tbl_rd_en);
  a_r11_read_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd_en |-> $past(load_accept));
  a_r2_busy_during_read: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd_en |-> !ready);
  a_r2_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> ready);
  a_r10_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(sel_visible));
  a_r3_absent_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && load_code == F_ABSENT) |-> !seg_ok);
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
  import seg_pkg::*;
#(
  parameter int BASE_W = 24,
  parameter int LIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              seg_ok,
  input  logic              seg_code,
  input  logic [BASE_W-1:0] seg_base,
  input  logic [LIM_W-1:0]  seg_limit,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic [LIM_W-1:0]  acc_offset,
  output logic              res_valid,
  output logic [BASE_W-1:0] res_linear,
  output logic [2:0]        res_fault
);
  // busy, then invalid, then limit, then type
  function automatic fault_e classify(input logic b, input logic ok, input logic code,
                                      input logic [1:0] kind, input logic [LIM_W-1:0] off,
                                      input logic [LIM_W-1:0] lim);
    if (b)                              return F_BUSY;
    if (!ok)                            return F_INVALID;
    if (off > lim)                      return F_LIMIT;
    if (kind == ACC_WRITE && code)      return F_WR_CODE;
    if (kind == ACC_FETCH && !code)     return F_EX_DATA;
    return F_NONE;
  endfunction

  function automatic logic [BASE_W-1:0] lin_addr(input logic [BASE_W-1:0] b,
                                                 input logic [LIM_W-1:0] off);
    return b + BASE_W'(off);
  endfunction

  fault_e            verdict;
  logic [BASE_W-1:0] lin_w;

  assign verdict = classify(busy, seg_ok, seg_code, acc_kind, acc_offset, seg_limit);
  assign lin_w   = lin_addr(seg_base, acc_offset);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_linear <= '0;
      res_fault  <= F_NONE;
    end else begin
      res_valid <= acc_valid;
      if (acc_valid) begin
        res_fault  <= verdict;
        res_linear <= (verdict == F_NONE) ? lin_w : '0;
      end
    end
  end

  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> res_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !res_valid);
  a_r9_zero_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault != F_NONE) |-> res_linear == '0);
  a_r6_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault == F_NONE) |-> $past(acc_offset) <= $past(seg_limit));
  a_r4_busy_code: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && busy) |=> res_fault == F_BUSY);
endmodule

// File: rtl/seg_reg_unit.sv
module seg_reg_unit
  import seg_pkg::*;
#(
  parameter int IDX_W  = 13,
  parameter int BASE_W = 24,
  parameter int LIM_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel_load,
  input  logic [IDX_W:0]            sel_value,
  output logic [IDX_W:0]            sel_visible,
  output logic                      ready,
  output logic                      load_done,
  output logic [2:0]                load_fault,
  output logic                      tbl_rd_en,
  output logic [IDX_W:0]            tbl_rd_addr,
  input  logic [BASE_W+LIM_W+1:0]   tbl_rd_data,
  input  logic                      tbl_rd_valid,
  input  logic                      acc_valid,
  input  logic [1:0]                acc_kind,
  input  logic [LIM_W-1:0]          acc_offset,
  output logic                      res_valid,
  output logic [BASE_W-1:0]         res_linear,
  output logic [2:0]                res_fault
);
  logic              seg_ok;
  logic              seg_code;
  logic [BASE_W-1:0] seg_base;
  logic [LIM_W-1:0]  seg_limit;

  seg_desc_fetch #(.IDX_W(IDX_W), .BASE_W(BASE_W), .LIM_W(LIM_W)) i_fetch (
    .clk(clk), .rst_n(rst_n),
    .sel_load(sel_load), .sel_value(sel_value), .sel_visible(sel_visible),
    .ready(ready), .load_done(load_done), .load_code(load_fault),
    .tbl_rd_en(tbl_rd_en), .tbl_rd_addr(tbl_rd_addr),
    .tbl_rd_data(tbl_rd_data), .tbl_rd_valid(tbl_rd_valid),
    .seg_ok(seg_ok), .seg_code(seg_code), .seg_base(seg_base), .seg_limit(seg_limit)
  );

  seg_access_check #(.BASE_W(BASE_W), .LIM_W(LIM_W)) i_check (
    .clk(clk), .rst_n(rst_n),
    .busy(!ready), .seg_ok(seg_ok), .seg_code(seg_code),
    .seg_base(seg_base), .seg_limit(seg_limit),
    .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_offset(acc_offset),
    .res_valid(res_valid), .res_linear(res_linear), .res_fault(res_fault)
  );

  a_r4_no_read_from_access: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && ready && !sel_load) |=> !tbl_rd_en);
endmodule

// File: tb/test_seg_reg_unit.sv
module test_seg_reg_unit;
  localparam int IDX_W  = 4;
  localparam int BASE_W = 20;
  localparam int LIM_W  = 16;
  localparam int N_ENT  = 1 << (IDX_W + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_load = 1'b0;
  logic [IDX_W:0] sel_value = '0;
  logic [IDX_W:0] sel_visible;
  logic ready, load_done;
  logic [2:0] load_fault;
  logic tbl_rd_en;
  logic [IDX_W:0] tbl_rd_addr;
  logic [BASE_W+LIM_W+1:0] tbl_rd_data;
  logic tbl_rd_valid;
  logic acc_valid = 1'b0;
  logic [1:0] acc_kind = 2'd0;
  logic [LIM_W-1:0] acc_offset = '0;
  logic res_valid;
  logic [BASE_W-1:0] res_linear;
  logic [2:0] res_fault;

  int checks = 0;
  int errors = 0;
  int reads_seen = 0;
  int loads_acc = 0;
  int exp_addr = 0;
  int cur_lat = 1;
  int cnt = 0;
  int cap_addr = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  seg_reg_unit #(.IDX_W(IDX_W), .BASE_W(BASE_W), .LIM_W(LIM_W)) i_seg_reg_unit (
    .clk(clk), .rst_n(rst_n), .sel_load(sel_load), .sel_value(sel_value),
    .sel_visible(sel_visible), .ready(ready), .load_done(load_done),
    .load_fault(load_fault), .tbl_rd_en(tbl_rd_en), .tbl_rd_addr(tbl_rd_addr),
    .tbl_rd_data(tbl_rd_data), .tbl_rd_valid(tbl_rd_valid), .acc_valid(acc_valid),
    .acc_kind(acc_kind), .acc_offset(acc_offset), .res_valid(res_valid),
    .res_linear(res_linear), .res_fault(res_fault)
  );

  function automatic logic [BASE_W+LIM_W+1:0] desc_of(input int a);
    logic pres, code;
    logic [LIM_W-1:0] lim;
    logic [BASE_W-1:0] base;
    pres = (a % 7) != 5;
    code = ((a / 3) % 2) == 1;
    if (a == 0) lim = '0;
    else if (a == N_ENT - 1) lim = '1;
    else lim = LIM_W'((a * 613 + 17) % 65536);
    if (a == N_ENT - 2) base = 20'hFFFF0;
    else base = BASE_W'((a * 40503 + 2469) % (1 << BASE_W));
    return {base, lim, code, pres};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, expv);
    end
  endtask

  // table model: returns data cur_lat cycles after the read request
  assign tbl_rd_valid = (cnt == 1);
  assign tbl_rd_data  = desc_of(cap_addr);

  always @(posedge clk) begin
    cycles++;
    if (tbl_rd_en) begin
      reads_seen++;
      cap_addr = int'(tbl_rd_addr);
      cnt = cur_lat;
      chk(int'(tbl_rd_addr) == exp_addr, "R1 table address", int'(tbl_rd_addr), exp_addr);
    end else if (cnt != 0) begin
      cnt = cnt - 1;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    while (cycles < 100000) @(posedge clk);
    chk(1'b0, "watchdog", cycles, 0);
    finish_run();
  end

  task automatic access(input int kind, input int off, input int expf, input int expl,
                        input string req);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_kind = 2'(kind);
    acc_offset = LIM_W'(off);
    @(negedge clk);
    acc_valid = 1'b0;
    chk(res_valid == 1'b1, {req, " result valid"}, int'(res_valid), 1);
    chk(int'(res_fault) == expf, {req, " fault code"}, int'(res_fault), expf);
    chk(int'(res_linear) == expl, {req, " linear address"}, int'(res_linear), expl);
  endtask

  function automatic string tag_of(input int f);
    case (f)
      2: return "R6";
      3: return "R7";
      4: return "R8";
      6: return "R5";
      default: return "R9";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R12 ready after reset", int'(ready), 1);
    chk(res_valid == 1'b0, "R12 no result after reset", int'(res_valid), 0);
    chk(load_done == 1'b0, "R12 no load after reset", int'(load_done), 0);
    chk(tbl_rd_en == 1'b0, "R12 no read after reset", int'(tbl_rd_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    access(0, 0, 6, 0, "R5 never loaded");
    access(2, 5, 6, 0, "R12 invalid after reset");

    for (int a = 0; a < N_ENT; a++) begin
      logic [BASE_W+LIM_W+1:0] d;
      logic [IDX_W:0] sel;
      logic [IDX_W:0] other;
      int lim, base, wait_n;
      bit pres, code;
      d = desc_of(a);
      pres = d[0];
      code = d[1];
      lim = int'(d[LIM_W+1:2]);
      base = int'(d[BASE_W+LIM_W+1:LIM_W+2]);
      sel = {4'(a), 1'(a >> IDX_W)};
      other = ~sel;
      cur_lat = 1 + (a % 3);
      exp_addr = a;
      @(negedge clk);
      sel_load = 1'b1;
      sel_value = sel;
      loads_acc++;
      @(negedge clk);
      chk(ready == 1'b0, "R2 ready low while fetching", int'(ready), 0);
      chk(sel_visible == sel, "R1 selector captured", int'(sel_visible), int'(sel));
      sel_value = other;
      acc_valid = 1'b1;
      acc_kind = 2'd0;
      acc_offset = '0;
      @(negedge clk);
      sel_load = 1'b0;
      acc_valid = 1'b0;
      chk(res_valid && int'(res_fault) == 5, "R4 busy access", int'(res_fault), 5);
      chk(res_linear == '0, "R4 busy linear zero", int'(res_linear), 0);
      wait_n = 0;
      while (!load_done && wait_n < 20) begin
        @(negedge clk);
        wait_n++;
      end
      chk(load_done == 1'b1, "R2 load completes", int'(load_done), 1);
      chk(ready == 1'b1, "R2 ready with done", int'(ready), 1);
      chk(int'(load_fault) == (pres ? 0 : 1), "R3 load code", int'(load_fault), pres ? 0 : 1);
      chk(sel_visible == sel, "R10 busy write ignored", int'(sel_visible), int'(sel));
      chk(reads_seen == loads_acc, "R11 reads equal loads", reads_seen, loads_acc);
      @(negedge clk);
      chk(load_done == 1'b0, "R2 done is one pulse", int'(load_done), 0);
      if (!pres) begin
        access(0, 0, 6, 0, "R3 absent segment unusable");
      end else begin
        int offs[5];
        offs[0] = 0; offs[1] = lim; offs[2] = lim + 1; offs[3] = 65535; offs[4] = lim / 2;
        for (int k = 0; k < 4; k++) begin
          for (int j = 0; j < 5; j++) begin
            int f, l;
            if (offs[j] > 65535) continue;
            if (offs[j] > lim) f = 2;
            else if (k == 1 && code) f = 3;
            else if (k == 2 && !code) f = 4;
            else f = 0;
            l = (f == 0) ? ((base + offs[j]) % (1 << BASE_W)) : 0;
            access(k, offs[j], f, l, tag_of(f));
          end
        end
      end
    end
    chk(reads_seen == loads_acc, "R11 final read count", reads_seen, loads_acc);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule